// File: doc/BRIEF.md
# SPI Register Slave with Burst Auto-Increment

This block is a SPI target that gives an external host access to a small, sparse map of byte-wide registers. The map has two banks. The configuration bank starts with a read-only revision byte, followed by eleven writable bytes. The data bank is read-only and holds a live status byte, a 16-bit proximity value and a 24-bit frequency count. The proximity and frequency values arrive on parallel input ports. Every writable configuration byte is also presented on a flat output bus, so that neighbouring logic can use it.

A transaction opens with a command byte, followed by one or more data bytes. While chip select stays low after the first data byte, the access turns into a burst, and the register address steps by one for each further byte. When a burst read starts at the first measurement byte, it returns all five measurement bytes from a single capture instant, even if the inputs change during the transfer. The serial pins are treated as synchronous to the system clock, and edges are found by oversampling SCLK. Any synchronizers belong to the surrounding logic.

Top module: `spiRegSlave`

## Requirements
- R1: After reset, every configuration byte on `cfgRegs` is 0x00 and `miso` is low.
- R2: Each byte is sampled MSB first on rising SCLK and shifted out on falling SCLK (mode 0). In the command byte, bit 7 is the read flag (1 = read) and bits 6:0 are the start address. A 16-edge transaction accesses exactly one register.
- R3: A byte written to an address from 0x01 to 0x0B is committed once its eighth rising edge has been sampled. It appears on `cfgRegs` bits [8*(a-1)+7 : 8*(a-1)], and a later read of that address returns it.
- R4: While chip select stays low, each further data byte goes to, or comes from, the next address. This holds for both writes and reads.
- R5: The address counter wraps from 0x7F to 0x00 during a burst.
- R6: Address 0x00 reads the revision parameter (default 0x80). Writes to 0x00, to 0x20 through 0x25 and to unmapped addresses change nothing.
- R7: Reads of addresses outside 0x00–0x0B and 0x20–0x25 return 0x00.
- R8: Address 0x20 returns the `statusIn` value at the moment its byte is loaded for shifting.
- R9: Loading address 0x21 for a read captures `proxData` and `freqData` together. Addresses 0x21/0x22 then return proximity bits 7:0 and 15:8, and 0x23/0x24/0x25 return frequency bits 7:0, 15:8 and 23:16, all from that capture.
- R10: Raising chip select partway through a byte discards that byte without writing. The next transaction begins with a command byte.
- R11: `miso` is low whenever chip select is high, during the command byte, and throughout a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rstN | input | 1 | Active-low synchronous reset |
| sclk | input | 1 | Serial clock from the host |
| csN | input | 1 | Active-low chip select |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| statusIn | input | 8 | Live status byte served at 0x20 |
| proxData | input | 16 | Proximity measurement |
| freqData | input | 24 | Frequency count measurement |
| cfgRegs | output | 88 | Writable configuration bytes, address 0x01 in the low byte |

## Verification
On every cycle, the checker confirms four things: `miso` stays quiet while deselected, configuration bytes never change after a cycle in which chip select was high, each completed data byte advances the address by one modulo 128, and the end of a command byte never coincides with the end of a data byte. Several behaviours can only be shown by the bench's transfers: that burst snapshot bytes stay coherent while the inputs change mid-transfer, that aborted partial bytes are discarded, that reads wrap through 0x7F into the revision byte, and that read-only or unmapped writes are dropped.

// File: rtl/spiRegPkg.sv
package spiRegPkg;
  localparam int ADDR_W = 7;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W);

  typedef enum logic {PH_CMD, PH_DATA} phaseT;

  // strobes from control to datapath, one clk wide each
  typedef struct packed {
    logic shiftRx;      // rising SCLK while selected
    logic cmdDone;      // eighth bit of the command byte
    logic dataByteEnd;  // eighth bit of any data byte
    logic wrByte;       // commit rxNext to curAddr
    logic loadTx;       // load read byte at loadAddr
    logic shiftTx;      // advance outgoing byte
  } strobeT;
endpackage

// File: rtl/spiRegCtrl.sv
module spiRegCtrl
  import spiRegPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclk,
  input  logic              csN,
  input  logic [BYTE_W-1:0] rxNext,
  output strobeT            strobes,
  output logic [ADDR_W-1:0] curAddr,
  output logic [ADDR_W-1:0] loadAddr,
  output logic              readMode
);
  logic             sclkQ;
  logic [CNT_W-1:0] bitCnt;
  phaseT            phase;
  logic             isRead;
  logic             sclkRise, sclkFall, byteEnd;

  assign sclkRise = sclk & ~sclkQ;
  assign sclkFall = ~sclk & sclkQ;
  assign byteEnd  = ~csN & sclkRise & (bitCnt == CNT_W'(BYTE_W - 1));
  assign readMode = ~csN & (phase == PH_DATA) & isRead;

  always_comb begin
    strobes             = '0;
    strobes.shiftRx     = ~csN & sclkRise;
    strobes.cmdDone     = byteEnd & (phase == PH_CMD);
    strobes.dataByteEnd = byteEnd & (phase == PH_DATA);
    strobes.wrByte      = strobes.dataByteEnd & ~isRead;
    strobes.loadTx      = (strobes.cmdDone & rxNext[BYTE_W-1]) |
                          (strobes.dataByteEnd & isRead);
    // no shift on the fall that opens a new byte: its MSB is already out
    strobes.shiftTx     = readMode & sclkFall & (bitCnt != '0);
    loadAddr            = strobes.cmdDone ? rxNext[ADDR_W-1:0] : curAddr + ADDR_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclkQ   <= 1'b0;
      bitCnt  <= '0;
      phase   <= PH_CMD;
      isRead  <= 1'b0;
      curAddr <= '0;
    end else begin
      sclkQ <= sclk;
      if (csN) begin
        bitCnt <= '0;
        phase  <= PH_CMD;
        isRead <= 1'b0;
      end else begin
        if (sclkRise) bitCnt <= bitCnt + CNT_W'(1);
        if (strobes.cmdDone) begin
          phase   <= PH_DATA;
          isRead  <= rxNext[BYTE_W-1];
          curAddr <= rxNext[ADDR_W-1:0];
        end else if (strobes.dataByteEnd) begin
          curAddr <= curAddr + ADDR_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/spiRegData.sv
module spiRegData
  import spiRegPkg::*;
#(
  parameter logic [7:0] REV_ID     = 8'h80,
  parameter int         CFG_BASE   = 1,
  parameter int         CFG_COUNT  = 11,
  parameter int         STAT_ADDR  = 32,
  parameter int         PROX_BYTES = 2,
  parameter int         FREQ_BYTES = 3
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         csN,
  input  logic                         mosi,
  input  strobeT                       strobes,
  input  logic [ADDR_W-1:0]            curAddr,
  input  logic [ADDR_W-1:0]            loadAddr,
  input  logic                         readMode,
  input  logic [BYTE_W-1:0]            statusIn,
  input  logic [8*PROX_BYTES-1:0]      proxData,
  input  logic [8*FREQ_BYTES-1:0]      freqData,
  output logic [BYTE_W-1:0]            rxNext,
  output logic                         miso,
  output logic [8*CFG_COUNT-1:0]       cfgFlat
);
  localparam int SNAP_BYTES = PROX_BYTES + FREQ_BYTES;
  localparam int SNAP_W     = 8 * SNAP_BYTES;
  localparam int SNAP_BASE  = STAT_ADDR + 1;

  logic [BYTE_W-1:0] rxShift, txShift, rdByte;
  logic [SNAP_W-1:0] liveSnap;
  logic [SNAP_W-9:0] snapHi;
  logic              snapTake;

  assign rxNext   = {rxShift[BYTE_W-2:0], mosi};
  assign liveSnap = {freqData, proxData};
  assign snapTake = strobes.loadTx && (loadAddr == ADDR_W'(SNAP_BASE));
  assign miso     = readMode & txShift[BYTE_W-1];

  for (genvar i = 0; i < CFG_COUNT; i++) begin : gCfg
    logic [BYTE_W-1:0] regQ;
    always_ff @(posedge clk) begin
      if (!rstN) regQ <= '0;
      else if (strobes.wrByte && (curAddr == ADDR_W'(CFG_BASE + i))) regQ <= rxNext;
    end
    assign cfgFlat[8*i +: 8] = regQ;
  end

  always_comb begin
    rdByte = '0;
    if (loadAddr == '0) rdByte = REV_ID;
    for (int i = 0; i < CFG_COUNT; i++)
      if (loadAddr == ADDR_W'(CFG_BASE + i)) rdByte = cfgFlat[8*i +: 8];
    if (loadAddr == ADDR_W'(STAT_ADDR)) rdByte = statusIn;
    // first snapshot byte comes straight from the inputs being captured now
    if (loadAddr == ADDR_W'(SNAP_BASE)) rdByte = liveSnap[7:0];
    for (int j = 1; j < SNAP_BYTES; j++)
      if (loadAddr == ADDR_W'(SNAP_BASE + j)) rdByte = snapHi[8*(j-1) +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxShift <= '0;
      txShift <= '0;
      snapHi  <= '0;
    end else begin
      if (csN) rxShift <= '0;
      else if (strobes.shiftRx) rxShift <= rxNext;

      if (strobes.loadTx) txShift <= rdByte;
      else if (strobes.shiftTx) txShift <= {txShift[BYTE_W-2:0], 1'b0};
      else if (csN) txShift <= '0;

      if (snapTake) snapHi <= liveSnap[SNAP_W-1:8];
    end
  end
endmodule

// File: rtl/spiRegSlave.sv
module spiRegSlave
  import spiRegPkg::*;
#(
  parameter logic [7:0] REV_ID     = 8'h80,
  parameter int         CFG_BASE   = 1,
  parameter int         CFG_COUNT  = 11,
  parameter int         STAT_ADDR  = 32,
  parameter int         PROX_BYTES = 2,
  parameter int         FREQ_BYTES = 3
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    sclk,
  input  logic                    csN,
  input  logic                    mosi,
  output logic                    miso,
  input  logic [7:0]              statusIn,
  input  logic [8*PROX_BYTES-1:0] proxData,
  input  logic [8*FREQ_BYTES-1:0] freqData,
  output logic [8*CFG_COUNT-1:0]  cfgRegs
);
  strobeT            strobes;
  logic [ADDR_W-1:0] curAddr, loadAddr;
  logic              readMode;
  logic [BYTE_W-1:0] rxNext;

  spiRegCtrl uCtrl (
    .clk(clk), .rstN(rstN), .sclk(sclk), .csN(csN), .rxNext(rxNext),
    .strobes(strobes), .curAddr(curAddr), .loadAddr(loadAddr), .readMode(readMode)
  );

  spiRegData #(
    .REV_ID(REV_ID), .CFG_BASE(CFG_BASE), .CFG_COUNT(CFG_COUNT),
    .STAT_ADDR(STAT_ADDR), .PROX_BYTES(PROX_BYTES), .FREQ_BYTES(FREQ_BYTES)
  ) uData (
    .clk(clk), .rstN(rstN), .csN(csN), .mosi(mosi), .strobes(strobes),
    .curAddr(curAddr), .loadAddr(loadAddr), .readMode(readMode),
    .statusIn(statusIn), .proxData(proxData), .freqData(freqData),
    .rxNext(rxNext), .miso(miso), .cfgFlat(cfgRegs)
  );
endmodule

// File: rtl/spiRegSlaveChk.sv
module spiRegSlaveChk
  import spiRegPkg::*;
#(
  parameter int CFG_COUNT = 11
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   csN,
  input logic                   miso,
  input logic [8*CFG_COUNT-1:0] cfgRegs,
  input strobeT                 strobes,
  input logic [ADDR_W-1:0]      curAddr
);
  // R11
  miso_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !miso);

  // R10
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(csN) |-> $stable(cfgRegs));

  // R4 R5
  addr_inc_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.dataByteEnd |=> (curAddr == $past(curAddr) + ADDR_W'(1)));

  // R2
  phase_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.cmdDone, strobes.dataByteEnd}));
endmodule

bind spiRegSlave spiRegSlaveChk #(.CFG_COUNT(CFG_COUNT)) uChk (.*);

// File: tb/tb_spiRegSlave.sv
module tb_spiRegSlave;
  localparam int HALF = 4;
  localparam int NVEC = 13;
  // {write=0/read=1, addr, write data, expected read}
  localparam logic [23:0] VEC [NVEC] = '{
    {1'b0, 7'h03, 8'hA5, 8'h00}, {1'b1, 7'h03, 8'h00, 8'hA5},
    {1'b0, 7'h00, 8'hFF, 8'h00}, {1'b1, 7'h00, 8'h00, 8'h80},
    {1'b0, 7'h10, 8'h55, 8'h00}, {1'b1, 7'h10, 8'h00, 8'h00},
    {1'b0, 7'h20, 8'h11, 8'h00}, {1'b1, 7'h20, 8'h00, 8'h3C},
    {1'b0, 7'h0B, 8'h7E, 8'h00}, {1'b1, 7'h0B, 8'h00, 8'h7E},
    {1'b0, 7'h23, 8'h99, 8'h00}, {1'b1, 7'h26, 8'h00, 8'h00},
    {1'b1, 7'h0C, 8'h00, 8'h00}
  };

  logic clk = 1'b0, rstN = 1'b0, sclk = 1'b0, csN = 1'b1, mosi = 1'b0;
  logic miso;
  logic [7:0]  statusIn = 8'h3C;
  logic [15:0] proxData = 16'h0;
  logic [23:0] freqData = 24'h0;
  logic [87:0] cfgRegs;
  int chkCnt = 0, errCnt = 0;

  always #2.5 clk = ~clk;

  spiRegSlave dut (
    .clk(clk), .rstN(rstN), .sclk(sclk), .csN(csN), .mosi(mosi), .miso(miso),
    .statusIn(statusIn), .proxData(proxData), .freqData(freqData), .cfgRegs(cfgRegs)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    chkCnt++;
    if (act !== exp) begin
      errCnt++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic spiBits(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
    rx = '0;
    for (int b = 7; b > 7 - nbits; b--) begin
      mosi = tx[b];
      waitClk(HALF);
      rx[b] = miso;
      sclk = 1'b1;
      waitClk(HALF);
      sclk = 1'b0;
    end
  endtask

  task automatic csLow();
    csN = 1'b0;
    waitClk(HALF);
  endtask

  task automatic csHigh();
    waitClk(HALF);
    csN = 1'b1;
    waitClk(2 * HALF);
  endtask

  task automatic readOne(input logic [6:0] a, output logic [7:0] rx);
    logic [7:0] d;
    csLow();
    spiBits({1'b1, a}, 8, d);
    spiBits(8'h00, 8, rx);
    csHigh();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chkCnt++;
    errCnt++;
    $display("FAIL watchdog expired actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", chkCnt, errCnt);
    $finish;
  end

  initial begin
    logic [7:0] rx, d;
    waitClk(5);
    // R1: reset state
    check("R1 cfgRegs after reset", cfgRegs, 88'h0);
    check("R1 miso after reset", miso, 1'b0);
    rstN = 1'b1;
    waitClk(3);

    // R2 R3 R6 R7 R8 R11: single-register vector table
    for (int v = 0; v < NVEC; v++) begin
      csLow();
      spiBits({VEC[v][23], VEC[v][22:16]}, 8, d);
      check($sformatf("R11 miso during command v%0d", v), d, 8'h00);
      spiBits(VEC[v][15:8], 8, rx);
      csHigh();
      if (VEC[v][23])
        check($sformatf("R2/R3/R6/R7/R8 read v%0d", v), rx, VEC[v][7:0]);
      else
        check($sformatf("R11 miso during write v%0d", v), rx, 8'h00);
    end
    check("R3 cfgRegs byte of 0x03", cfgRegs[23:16], 8'hA5);

    // R4: burst write from 0x01
    csLow();
    spiBits(8'h01, 8, d);
    spiBits(8'h11, 8, d);
    spiBits(8'h22, 8, d);
    spiBits(8'h33, 8, d);
    spiBits(8'h44, 8, d);
    csHigh();
    check("R4 burst write", cfgRegs[31:0], 32'h44332211);

    // R4 R7: burst read 0x0A..0x0C crosses into the unmapped gap
    csLow();
    spiBits(8'h8A, 8, d);
    spiBits(8'h00, 8, rx); check("R4 burst read 0x0A", rx, 8'h00);
    spiBits(8'h00, 8, rx); check("R4 burst read 0x0B", rx, 8'h7E);
    spiBits(8'h00, 8, rx); check("R7 burst read 0x0C", rx, 8'h00);
    csHigh();

    // R5: wrap from 0x7F into the revision byte
    csLow();
    spiBits(8'hFF, 8, d);
    spiBits(8'h00, 8, rx); check("R5 read 0x7F", rx, 8'h00);
    spiBits(8'h00, 8, rx); check("R5 wrapped read 0x00", rx, 8'h80);
    csHigh();

    // R9: coherent snapshot while inputs change mid-burst
    proxData = 16'h1234;
    freqData = 24'hABCDEF;
    csLow();
    spiBits(8'hA1, 8, d);
    proxData = 16'hFFFF;
    freqData = 24'h000000;
    spiBits(8'h00, 8, rx); check("R9 snap 0x21", rx, 8'h34);
    spiBits(8'h00, 8, rx); check("R9 snap 0x22", rx, 8'h12);
    spiBits(8'h00, 8, rx); check("R9 snap 0x23", rx, 8'hEF);
    spiBits(8'h00, 8, rx); check("R9 snap 0x24", rx, 8'hCD);
    spiBits(8'h00, 8, rx); check("R9 snap 0x25", rx, 8'hAB);
    csHigh();
    csLow();
    spiBits(8'hA1, 8, d);
    spiBits(8'h00, 8, rx); check("R9 new snap 0x21", rx, 8'hFF);
    spiBits(8'h00, 8, rx); check("R9 new snap 0x22", rx, 8'hFF);
    csHigh();

    // R8: status is live
    statusIn = 8'hC3;
    readOne(7'h20, rx);
    check("R8 live status", rx, 8'hC3);

    // R10: partial byte is discarded
    csLow();
    spiBits(8'h05, 8, d);
    spiBits(8'h5A, 8, d);
    csHigh();
    csLow();
    spiBits(8'h05, 8, d);
    spiBits(8'hFF, 5, d);
    csHigh();
    check("R10 partial write dropped", cfgRegs[39:32], 8'h5A);
    readOne(7'h05, rx);
    check("R10 next transaction starts with command", rx, 8'h5A);
    check("R11 miso idle", miso, 1'b0);

    $display("CHECKS %0d ERRORS %0d", chkCnt, errCnt);
    $finish;
  end
endmodule